// File: doc/BRIEF.md
# PWM Compare Timer

This block is an up-counting timer that shapes a pulse-width waveform with two compare values. A free-running counter starts at zero and advances once for each system clock cycle in which the count enable and the run control are both high. When the counter holds the value of compare B at a count step, it returns to zero on that step. One period is therefore compare B plus one counts long. Compare A sets where the waveform turns on. On the count step that moves the counter from compare A to the next value, the output becomes active and a one-clock compare-A interrupt cause is raised. On the wrap at compare B, the output returns to inactive and a one-clock compare-B interrupt cause is raised.

The waveform is held in a two-state phase machine. In state WAIT the output is inactive. In state DRIVE the output is active. The machine has three transitions. WAIT goes to DRIVE on a compare-A event. DRIVE goes to WAIT on a compare-B event. Any state goes to WAIT on a software clear. The pin level is the phase, gated by the output enable, XORed with the initial-level bit and the inversion bit. As a result, a stopped output and the start of each period both show the initial level XOR inversion, and the active part shows the opposite level. The software clear zeroes the counter and drops the phase to WAIT, whether the timer is running or not.

Top module: `pwm_cmp_timer`

## Requirements
- R1: While reset is held and right after it is released, both interrupt causes are 0, the counter is 0 and the phase is WAIT. The pin therefore shows init_lvl XOR inv_sel.
- R2: The counter advances by one only on clock cycles where run and cnt_en are both 1. On all other cycles it holds its value, and no event, pulse or level change occurs.
- R3: A count step taken while the counter equals cmp_b loads 0. With a steady count enable, compare-B pulses are therefore cmp_b+1 cycles apart.
- R4: A count step taken while the counter equals cmp_a, with cmp_a < cmp_b, makes the phase DRIVE. irq_a is 1 for the clock cycle that follows that step.
- R5: The wrap step at cmp_b makes the phase WAIT. irq_b is 1 for the clock cycle that follows that step.
- R6: With out_en = 1, the pin is init_lvl XOR inv_sel in WAIT and the inverse of that level in DRIVE. Setting inv_sel inverts every level.
- R7: With out_en = 0, the pin is init_lvl XOR inv_sel. Counting and interrupt causes continue unchanged.
- R8: cnt_clr = 1 loads 0 into the counter, puts the phase in WAIT and clears both interrupt causes on the next edge. It takes priority over counting.
- R9: When cmp_a >= cmp_b, the phase never enters DRIVE and irq_a stays 0.
- R10: irq_a and irq_b are never 1 in the same cycle, and irq_a is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count clock enable, one count per high cycle |
| run | input | 1 | Run control; 0 freezes the counter |
| cnt_clr | input | 1 | Software clear of counter and phase |
| out_en | input | 1 | Drives the waveform onto the pin when 1 |
| init_lvl | input | 1 | Initial output level select |
| inv_sel | input | 1 | Output inversion select |
| cmp_a | input | CNT_W | Compare A, the turn-on point |
| cmp_b | input | CNT_W | Compare B, the period end |
| pwm_out | output | 1 | Waveform pin level |
| irq_a | output | 1 | Compare-A interrupt cause pulse |
| irq_b | output | 1 | Compare-B interrupt cause pulse |

## Verification
The counter cannot be seen at the ports. A wrong count shows up only when the waveform edges or the interrupt pulses that follow from it land in the wrong cycle. A counter that is off by one moves the next compare-A or compare-B pulse by one cycle, inside the period in which the error occurs, so comparing every cycle against a model catches it within cmp_b+1 count steps. A stuck or wrong phase shows at once on the pin while out_en is 1. While out_en is 0 it stays hidden until the output is enabled again.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    typedef enum logic [0:0] {
        PH_WAIT  = 1'b0,
        PH_DRIVE = 1'b1
    } phase_e;

endpackage

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             evt_a,
    output logic             evt_b
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt;
    logic             at_b;
    logic             a_valid;

    always_comb begin
        at_b    = (cnt == cmp_b);
        a_valid = (cmp_a < cmp_b);
        evt_b   = step && at_b;
        evt_a   = step && !at_b && a_valid && (cnt == cmp_a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else if (clr) begin
            cnt <= CNT_ZERO;
        end else if (evt_b) begin
            cnt <= CNT_ZERO;
        end else if (step) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R2: no step and no clear leaves the count untouched
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt));

    // R2: an ordinary step adds exactly one
    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !evt_b) |=> (cnt == $past(cnt) + CNT_ONE));

    // R3: wrap at compare B lands on zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_b && !clr) |=> (cnt == CNT_ZERO));

    // R8: clear zeroes the counter
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == CNT_ZERO));

endmodule

// File: rtl/pwm_cmp_phase_fsm.sv
module pwm_cmp_phase_fsm
    import pwm_cmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   evt_a,
    input  logic   evt_b,
    output phase_e phase,
    output logic   irq_a,
    output logic   irq_b
);

    phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_WAIT:  if (evt_a) phase_nxt = PH_DRIVE;
            PH_DRIVE: if (evt_b) phase_nxt = PH_WAIT;
            default:  phase_nxt = PH_WAIT;
        endcase
        if (clr) phase_nxt = PH_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_WAIT;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_a <= 1'b0;
            irq_b <= 1'b0;
        end else begin
            irq_a <= evt_a && !clr;
            irq_b <= evt_b && !clr;
        end
    end

    // R10: the two interrupt causes never coincide
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_a && irq_b));

    // R4: a compare-A pulse always accompanies the DRIVE phase
    p_a_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (phase == PH_DRIVE));

    // R5: a compare-B pulse always accompanies the WAIT phase
    p_b_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (phase == PH_WAIT));

    // R8: clear silences pulses and returns to WAIT
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!irq_a && !irq_b && phase == PH_WAIT));

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             run,
    input  logic             cnt_clr,
    input  logic             out_en,
    input  logic             init_lvl,
    input  logic             inv_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             pwm_out,
    output logic             irq_a,
    output logic             irq_b
);

    logic   step;
    logic   evt_a;
    logic   evt_b;
    phase_e phase;
    logic   drive_on;

    assign step = run && cnt_en && !cnt_clr;

    pwm_cmp_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (step),
        .cmp_a (cmp_a),
        .cmp_b (cmp_b),
        .evt_a (evt_a),
        .evt_b (evt_b)
    );

    pwm_cmp_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .evt_a (evt_a),
        .evt_b (evt_b),
        .phase (phase),
        .irq_a (irq_a),
        .irq_b (irq_b)
    );

    always_comb begin
        drive_on = out_en && (phase == PH_DRIVE);
        pwm_out  = drive_on ^ init_lvl ^ inv_sel;
    end

    // R9: with A not below B the phase cannot climb into DRIVE
    p_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a >= cmp_b && phase == PH_WAIT && !cnt_clr) |=> (phase == PH_WAIT));

    // R2: a frozen timer keeps its phase and raises no pulse
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && cnt_en) && !cnt_clr) |=> ($stable(phase) && !irq_a && !irq_b));

endmodule

// File: tb/pwm_cmp_timer_bench.sv
`timescale 1ns/1ps
module pwm_cmp_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, run = 1'b0, cnt_clr = 1'b0, out_en = 1'b0;
    logic         init_lvl = 1'b1, inv_sel = 1'b0;
    logic [W-1:0] cmp_a = '0, cmp_b = '0;
    logic         pwm_out, irq_a, irq_b;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R6";

    // model state
    logic [W-1:0] m_cnt;
    logic         m_act, m_ia, m_ib;
    logic         prev_ia = 1'b0;

    // period tracking for R3
    bit track = 0;
    int gap = 0;
    bit seen_b = 0;
    int exp_gap = 0;

    always #10 clk = ~clk;

    pwm_cmp_timer #(.CNT_W(W)) u_pwm_cmp_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run), .cnt_clr(cnt_clr),
        .out_en(out_en), .init_lvl(init_lvl), .inv_sel(inv_sel),
        .cmp_a(cmp_a), .cmp_b(cmp_b),
        .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
    );

    function automatic logic exp_pwm(input logic act, input logic oe,
                                     input logic il, input logic iv);
        return (act & oe) ^ il ^ iv;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = '0; m_act = 1'b0; m_ia = 1'b0; m_ib = 1'b0;
        end else if (cnt_clr) begin
            m_cnt = '0; m_act = 1'b0; m_ia = 1'b0; m_ib = 1'b0;
        end else begin
            m_ia = 1'b0; m_ib = 1'b0;
            if (run && cnt_en) begin
                if (m_cnt == cmp_b) begin
                    m_cnt = '0; m_act = 1'b0; m_ib = 1'b1;
                end else begin
                    if (m_cnt == cmp_a && cmp_a < cmp_b) begin
                        m_act = 1'b1; m_ia = 1'b1;
                    end
                    m_cnt = m_cnt + 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, pwm_out, exp_pwm(m_act, out_en, init_lvl, inv_sel));
        chk("R4 irq_a", irq_a, m_ia);
        chk("R5 irq_b", irq_b, m_ib);
        chk("R10 exclusive", irq_a & irq_b, 1'b0);
        if (prev_ia) chk("R10 single pulse", irq_a, 1'b0);
        prev_ia = irq_a;
        if (track) begin
            gap++;
            if (irq_b) begin
                if (seen_b) chk("R3 period", logic'(gap == exp_gap), 1'b1);
                seen_b = 1; gap = 0;
            end
        end
    endtask

    task automatic clear_pulse();
        cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state, init_lvl=1 inv_sel=0 gives pin 1
        chk("R1 pin in reset", pwm_out, 1'b1);
        chk("R1 irq_a in reset", irq_a, 1'b0);
        chk("R1 irq_b in reset", irq_b, 1'b0);
        rst_n = 1'b1;
        cur_req = "R1";
        cyc();

        // R4/R5/R3: A=3 B=5 directed, pin low on counts 0..3, high on 4,5
        init_lvl = 0; inv_sel = 0; out_en = 1; cmp_a = 3; cmp_b = 5;
        clear_pulse();
        run = 1; cnt_en = 1; cur_req = "R4";
        track = 1; seen_b = 0; gap = 0; exp_gap = 6;
        repeat (30) cyc();
        track = 0;

        // R6: inversion and initial level combinations
        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            init_lvl = k[0]; inv_sel = k[1];
            repeat (14) cyc();
        end

        // R7: output disabled, counting continues
        cur_req = "R7"; init_lvl = 1; inv_sel = 0; out_en = 0;
        repeat (15) cyc();
        out_en = 1; repeat (8) cyc();

        // R2: gated count enable and run
        cur_req = "R2";
        for (int i = 0; i < 60; i++) begin
            cnt_en = $urandom_range(0, 1); run = ($urandom_range(0, 3) != 0);
            cyc();
        end
        run = 1; cnt_en = 1;

        // R8: clear mid-period while running and while stopped
        cur_req = "R8"; cmp_a = 2; cmp_b = 9;
        repeat (5) cyc();
        clear_pulse();
        repeat (6) cyc();
        run = 0; clear_pulse(); repeat (3) cyc(); run = 1;
        repeat (12) cyc();

        // R9: A equal to B, then A above B
        cur_req = "R9"; cmp_a = 5; cmp_b = 5; clear_pulse();
        repeat (20) cyc();
        cmp_a = 7; cmp_b = 3; clear_pulse();
        repeat (20) cyc();

        // R3: compare B of zero wraps every step
        cur_req = "R3"; cmp_a = 0; cmp_b = 0; clear_pulse();
        track = 1; seen_b = 0; gap = 0; exp_gap = 1;
        repeat (8) cyc();
        cmp_b = 11; cmp_a = 4; clear_pulse(); seen_b = 0; gap = 0; exp_gap = 12;
        repeat (40) cyc();
        track = 0;

        // random mix, pin checks tagged R6
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            cnt_en   = ($urandom_range(0, 4) != 0);
            run      = ($urandom_range(0, 9) != 0);
            cnt_clr  = ($urandom_range(0, 40) == 0);
            out_en   = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 60) == 0) begin
                init_lvl = $urandom_range(0, 1); inv_sel = $urandom_range(0, 1);
            end
            if (cnt_clr) begin
                cmp_a = W'($urandom_range(0, 12)); cmp_b = W'($urandom_range(0, 12));
            end
            cyc();
        end
        cnt_clr = 0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule